// File: doc/BRIEF.md
# I2C SCL Period Generator

This block times the serial clock for an I2C master engine. A prescaler field divides the peripheral clock down to an internal reference rate, and a period field sets how many reference ticks one SCL period spans. The line is driven low for the first half of the period. It is then released, and the second half is only counted once the real line has been seen high through a synchroniser. Slow rise times and targets that hold the clock low therefore lengthen the period instead of being cut short.

The master engine holds `run_i` high for as long as it wants clock periods. It uses `fall_tick_o` and `rise_tick_o` to place its data changes and its sampling. The control word is captured only while the generator is idle, so a write that lands mid-transfer never changes a period already in progress.

States: `ST_IDLE` (line released, control word tracked), `ST_LOW` (line driven low, low half counted), `ST_WAIT` (line released, waiting for the synchronised line to read high), `ST_HIGH` (high half counted). Transitions: IDLE→LOW when `run_i` is high; LOW→WAIT when the low count completes; WAIT→HIGH when the synchronised line is high; HIGH→LOW when the high count completes and `run_i` is still high; HIGH→IDLE when the high count completes and `run_i` is low.

Top module: `i2c_scl_divider`

## Requirements
- R1: After reset the generator is idle: `busy_o`, `scl_low_o`, `ick_en_o`, `fall_tick_o` and `rise_tick_o` are all 0.
- R2: While busy in a counting phase, `ick_en_o` pulses once every (1 + D) peripheral clocks, where D = `ccr_i[1:0]`. It never pulses while idle.
- R3: With P = `ccr_i[7:2]` and N = 20 + 8·P, the low phase drives `scl_low_o` for exactly floor(N/2)·(1 + D) consecutive clocks.
- R4: After the line is released, the high count starts 3 clocks after the sensed line first reads high (two synchroniser flops plus the state change). The stretch from the fall of `scl_low_o` to the next period or to idle is therefore 3 + ceil(N/2)·(1 + D) clocks when the line rises at once.
- R5: If the sensed line stays low for S extra clocks after release, the high phase and everything after it are delayed by exactly S clocks.
- R6: A change of `ccr_i` while `busy_o` is high does not affect any period until the generator has returned to idle.
- R7: Lowering `run_i` lets the current period finish in full. The generator then goes idle with the line released and starts no further low phase.
- R8: `fall_tick_o` pulses in the first clock of each low phase and `rise_tick_o` in the first clock of each high phase. The two never coincide.
- R9: `busy_o` stays high from the first low phase until the last high phase has completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_i | input | 1 | Request for continuous SCL periods |
| ccr_i | input | 8 | Control word: [1:0] prescaler D, [7:2] period code P |
| scl_in_i | input | 1 | Sensed state of the SCL line |
| scl_low_o | output | 1 | 1 = pull SCL low, 0 = release |
| ick_en_o | output | 1 | Internal reference clock enable |
| fall_tick_o | output | 1 | First clock of a low phase |
| rise_tick_o | output | 1 | First clock of a high phase |
| busy_o | output | 1 | Generator is running a period |

## Verification
The bench builds the generator with its default widths: a 2-bit prescaler, a 6-bit period code, a base of 20 and a step of 8 ticks, and a two-stage synchroniser. These values put the smallest period (P = 0, D = 0) and the longest one (P = 63, D = 2, 786-clock halves) within a short run. They also cover every prescaler ratio exercised and line-hold delays of a few clocks. A control-word change in the middle of a run, followed by a new run, shows that the captured value is held while busy and tracked while idle.

// File: rtl/i2c_scl_pkg.sv
package i2c_scl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_WAIT = 2'd2,
        ST_HIGH = 2'd3
    } scl_state_e;

endpackage

// File: rtl/scl_prescaler.sv
module scl_prescaler #(
    parameter int DIV_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             count_i,
    input  logic             restart_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o,
    output logic             at_start_o
);

    logic [DIV_W-1:0] psc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            psc_q <= '0;
        end else if (restart_i || !count_i || psc_q == div_i) begin
            psc_q <= '0;
        end else begin
            psc_q <= psc_q + DIV_W'(1);
        end
    end

    assign tick_o     = count_i && (psc_q == div_i);
    assign at_start_o = (psc_q == '0);

endmodule

// File: rtl/scl_line_sync.sv
module scl_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);

    logic [STAGES-1:0] ff_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) ff_q[0] <= 1'b1;
                    else        ff_q[0] <= line_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) ff_q[g] <= 1'b1;
                    else        ff_q[g] <= ff_q[g-1];
                end
            end
        end
    endgenerate

    assign line_o = ff_q[STAGES-1];

endmodule

// File: rtl/scl_phase_len.sv
module scl_phase_len #(
    parameter int CODE_W   = 6,
    parameter int BASE_CYC = 20,
    parameter int STEP_CYC = 8,
    parameter int LEN_W    = 10
) (
    input  logic [CODE_W-1:0] code_i,
    output logic [LEN_W-1:0]  low_len_o,
    output logic [LEN_W-1:0]  high_len_o
);

    localparam int PER_W = LEN_W + 1;

    logic [PER_W-1:0] period;

    always_comb begin
        period     = PER_W'(BASE_CYC) + PER_W'(STEP_CYC) * PER_W'(code_i);
        low_len_o  = LEN_W'(period >> 1);
        high_len_o = LEN_W'(period - (period >> 1));
    end

endmodule

// File: rtl/i2c_scl_divider.sv
module i2c_scl_divider
    import i2c_scl_pkg::*;
#(
    parameter int CDF_W       = 2,
    parameter int SCGD_W      = 6,
    parameter int BASE_CYC    = 20,
    parameter int STEP_CYC    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     run_i,
    input  logic [CDF_W+SCGD_W-1:0]  ccr_i,
    input  logic                     scl_in_i,
    output logic                     scl_low_o,
    output logic                     ick_en_o,
    output logic                     fall_tick_o,
    output logic                     rise_tick_o,
    output logic                     busy_o
);

    localparam int CCR_W   = CDF_W + SCGD_W;
    localparam int MAX_PER = BASE_CYC + STEP_CYC * ((1 << SCGD_W) - 1);
    localparam int MAX_HALF = (MAX_PER + 1) / 2;
    localparam int CNT_W   = $clog2(MAX_HALF + 1);

    scl_state_e        state_q, state_d;
    logic [CCR_W-1:0]  cfg_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  low_len, high_len;
    logic              tick, at_start, line_hi, counting, restart;

    assign counting = (state_q == ST_LOW) || (state_q == ST_HIGH);
    assign restart  = (state_d != state_q);

    scl_prescaler #(.DIV_W(CDF_W)) u_psc (
        .clk        (clk),
        .rst_n      (rst_n),
        .count_i    (counting),
        .restart_i  (restart),
        .div_i      (cfg_q[CDF_W-1:0]),
        .tick_o     (tick),
        .at_start_o (at_start)
    );

    scl_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_i (scl_in_i),
        .line_o (line_hi)
    );

    scl_phase_len #(
        .CODE_W   (SCGD_W),
        .BASE_CYC (BASE_CYC),
        .STEP_CYC (STEP_CYC),
        .LEN_W    (CNT_W)
    ) u_len (
        .code_i     (cfg_q[CCR_W-1:CDF_W]),
        .low_len_o  (low_len),
        .high_len_o (high_len)
    );

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (run_i) state_d = ST_LOW;
            ST_LOW:  if (tick && cnt_q == low_len - CNT_W'(1)) state_d = ST_WAIT;
            ST_WAIT: if (line_hi) state_d = ST_HIGH;
            ST_HIGH: if (tick && cnt_q == high_len - CNT_W'(1))
                         state_d = run_i ? ST_LOW : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register, phase counter and captured control word
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            cfg_q   <= '0;
        end else begin
            state_q <= state_d;
            if (restart)   cnt_q <= '0;
            else if (tick) cnt_q <= cnt_q + CNT_W'(1);
            if (state_q == ST_IDLE) cfg_q <= ccr_i;
        end
    end

    // outputs
    always_comb begin
        scl_low_o   = (state_q == ST_LOW);
        busy_o      = (state_q != ST_IDLE);
        ick_en_o    = tick;
        fall_tick_o = (state_q == ST_LOW)  && at_start && (cnt_q == '0);
        rise_tick_o = (state_q == ST_HIGH) && at_start && (cnt_q == '0);
    end

endmodule

// File: rtl/i2c_scl_divider_chk.sv
module i2c_scl_divider_chk #(
    parameter int CCR_W   = 8,
    parameter int CNT_W   = 9,
    parameter int MAX_CNT = 262
) (
    input logic             clk,
    input logic             rst_n,
    input logic             scl_low_o,
    input logic             ick_en_o,
    input logic             fall_tick_o,
    input logic             rise_tick_o,
    input logic             busy_o,
    input logic [CCR_W-1:0] cfg_q,
    input logic [CNT_W-1:0] cnt_q
);

    assert_ick_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !ick_en_o);

    assert_low_needs_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        scl_low_o |-> busy_o);

    assert_cnt_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(MAX_CNT));

    assert_rise_on_released_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rise_tick_o |-> (!scl_low_o && !$past(scl_low_o)));

    assert_cfg_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(cfg_q));

    assert_idle_released_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (!scl_low_o && !$past(scl_low_o)));

    assert_fall_tick_at_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_low_o) |-> fall_tick_o);

    assert_ticks_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(fall_tick_o && rise_tick_o));

endmodule

bind i2c_scl_divider i2c_scl_divider_chk #(
    .CCR_W   (CCR_W),
    .CNT_W   (CNT_W),
    .MAX_CNT (MAX_HALF)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_low_o   (scl_low_o),
    .ick_en_o    (ick_en_o),
    .fall_tick_o (fall_tick_o),
    .rise_tick_o (rise_tick_o),
    .busy_o      (busy_o),
    .cfg_q       (cfg_q),
    .cnt_q       (cnt_q)
);

// File: tb/i2c_scl_divider_test.sv
module i2c_scl_divider_test;

    typedef struct {
        int    kind;   // 0 = low length, 1 = released length
        int    val;
        string req;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run = 1'b0;
    logic [7:0] ccr = 8'h00;
    logic       scl_line;
    logic       scl_low, ick_en, fall_tick, rise_tick, busy;

    int   n_checks = 0;
    int   n_fail = 0;
    int   stretch = 0;
    int   hold_cnt = 0;
    bit   finished = 0;
    exp_t exp_q[$];

    always #4 clk = ~clk;

    i2c_scl_divider uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_i       (run),
        .ccr_i       (ccr),
        .scl_in_i    (scl_line),
        .scl_low_o   (scl_low),
        .ick_en_o    (ick_en),
        .fall_tick_o (fall_tick),
        .rise_tick_o (rise_tick),
        .busy_o      (busy)
    );

    // line model: target holds SCL low for `stretch` clocks after release
    always @(posedge clk) begin
        if (scl_low) hold_cnt <= stretch;
        else if (hold_cnt != 0) hold_cnt <= hold_cnt - 1;
    end
    assign scl_line = !scl_low && (hold_cnt == 0);

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // driver: pushes the expected segment lengths, then runs the generator
    task automatic run_case(input int cdf, input int scgd, input int s,
                            input int n_per, input bit change_mid);
        int per, lo, hi, falls, cyc, last_ick;
        bit ick_seen, ick_done;
        exp_t e;
        per = 20 + 8 * scgd;
        lo  = (per / 2) * (cdf + 1);
        hi  = s + 3 + (per - per / 2) * (cdf + 1);
        for (int i = 0; i < n_per; i++) begin
            e.kind = 0; e.val = lo; e.req = change_mid ? "R6" : "R3";
            exp_q.push_back(e);
            e.kind = 1; e.val = hi; e.req = (s > 0) ? "R5" : "R4";
            exp_q.push_back(e);
        end
        @(negedge clk);
        stretch = s;
        ccr = {6'(scgd), 2'(cdf)};
        run = 1'b1;
        falls = 0; cyc = 0; last_ick = 0; ick_seen = 0; ick_done = 0;
        while (falls < n_per) begin
            @(negedge clk);
            cyc++;
            if (fall_tick) begin
                falls++;
                if (falls == 1 && change_mid) ccr = ~ccr;
            end
            if (ick_en && scl_low && !ick_done) begin
                if (ick_seen) begin
                    check(cyc - last_ick == cdf + 1, "R2", cyc - last_ick, cdf + 1);
                    ick_done = 1;
                end
                ick_seen = 1;
                last_ick = cyc;
            end
        end
        run = 1'b0;
        // R9: busy holds until the last period completes
        check(busy == 1'b1, "R9", busy, 1);
        while (busy) @(negedge clk);
        @(negedge clk);
        check(!busy && !scl_low && !ick_en, "R7", {busy, scl_low, ick_en}, 0);
    endtask

    // monitor: measures segments of the line drive and compares them
    initial begin
        bit   prev_low, prev_busy, gap_active;
        int   cnt;
        exp_t e;
        prev_low = 0; prev_busy = 0; gap_active = 0; cnt = 0;
        @(posedge rst_n);
        forever begin
            @(negedge clk);
            if (scl_low != prev_low) begin
                if (prev_low || gap_active) begin
                    if (exp_q.size() == 0) begin
                        check(0, "R3", cnt, -1);
                    end else begin
                        e = exp_q.pop_front();
                        check(e.kind == (prev_low ? 0 : 1) && e.val == cnt, e.req, cnt, e.val);
                    end
                end
                gap_active = prev_low;
                cnt = 1;
            end else if (prev_busy && !busy && gap_active) begin
                if (exp_q.size() == 0) begin
                    check(0, "R9", cnt, -1);
                end else begin
                    e = exp_q.pop_front();
                    check(e.kind == 1 && e.val == cnt, e.req, cnt, e.val);
                end
                gap_active = 0;
                cnt = 1;
            end else begin
                cnt++;
            end
            if (fall_tick || (scl_low && !prev_low))
                check(fall_tick == (scl_low && !prev_low), "R8", fall_tick, scl_low && !prev_low);
            if (rise_tick)
                check(gap_active && cnt == stretch + 4, "R8", cnt, stretch + 4);
            prev_low = scl_low;
            prev_busy = busy;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!busy && !scl_low && !ick_en && !fall_tick && !rise_tick, "R1",
              {busy, scl_low, ick_en, fall_tick, rise_tick}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!busy && !scl_low && !ick_en, "R1", {busy, scl_low, ick_en}, 0);

        run_case(0, 0, 0, 3, 0);
        run_case(3, 2, 0, 2, 0);
        run_case(1, 1, 5, 2, 1);   // control word flipped mid-run: R6
        run_case(0, 5, 2, 2, 0);
        run_case(2, 63, 0, 1, 0);

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R7", exp_q.size(), 0);
        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule